// File: doc/BRIEF.md
# Configuration Bank Crossing with Qualifier Bit

This block moves a bank of configuration words from a slow register-write clock domain into a faster processing clock domain. Software, or any slow master, loads the data words through a simple write port. As its last write it raises a single qualifier bit. Only that qualifier passes through a two-flop synchronizer. The data words reach the fast domain without any synchronizer.

When the fast domain sees the synchronized qualifier go high, it counts a fixed number of its own clocks. This lets the unsynchronized data settle. It then copies the whole bank into local shadow registers in one cycle and emits a one-cycle completion pulse, which can serve as an interrupt. There is no acknowledge path back to the write domain. The writer clears the qualifier and starts the next update only after the completion pulse has told it that the previous values were taken.

Top module: `cfgx_bank_xfer`

## Requirements
- R1: On a write-domain edge with `wr_en` high, an address below NUM_REGS loads data word `wr_addr` (word k occupies bits k*REG_W upward of the flat bank). Address NUM_REGS loads the qualifier from `wr_data[0]`. Any higher address changes nothing.
- R2: Each capture presents on `cfg_out` the data words as they stood when the qualifier was raised.
- R3: Only the qualifier crosses the domains, through two receive-domain flops. The data words are sampled directly, without a synchronizer.
- R4: A capture happens exactly SETTLE_CYCLES receive clocks after the receive cycle in which the synchronized qualifier is first seen high. Counted from the write edge that raises the qualifier, `done` is high after between SETTLE_CYCLES+2 and SETTLE_CYCLES+4 receive edges.
- R5: Only a rising edge of the qualifier starts a capture. While the qualifier stays high, rewriting it or changing data words produces neither `done` nor any change on `cfg_out`.
- R6: Without a rising edge of the qualifier there is never a capture or a `done` pulse, including writes of 0 to an already-low qualifier.
- R7: `cfg_out` changes only at a capture. `done` is high for exactly one receive cycle, the first cycle in which the new values are visible.
- R8: Each domain has its own synchronous active-low reset. While `wr_rst_n` is low, the data words and qualifier are cleared to 0. While `rx_rst_n` is low, the synchronizer, the settle counter, `cfg_out` and `done` are cleared to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wr_clk | input | 1 | Slow write-domain clock |
| wr_rst_n | input | 1 | Synchronous active-low reset, write domain |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | $clog2(NUM_REGS+1) | Word select; NUM_REGS selects the qualifier |
| wr_data | input | REG_W | Write data; bit 0 is the qualifier value |
| rx_clk | input | 1 | Fast receive-domain clock |
| rx_rst_n | input | 1 | Synchronous active-low reset, receive domain |
| cfg_out | output | NUM_REGS*REG_W | Captured shadow bank, word k at bits k*REG_W upward |
| done | output | 1 | One-cycle pulse marking a completed capture |

## Verification
The bench builds the block with NUM_REGS=5, REG_W=8 and SETTLE_CYCLES=3. It runs a write clock of 41.6 ns against a receive clock of 10.6 ns with an offset start, so the phase between the domains drifts from one update to the next. With five words, the 3-bit address has two unused codes (6 and 7), which lets the bench exercise the ignored-address case. A settle count of 3 makes the capture window distinct from the bare synchronizer delay. Random data, partial updates, and a qualifier held high while data changes each test the rising-edge rule and the snapshot rule against a scoreboard queue.

// File: rtl/cfgx_pkg.sv
// Shared types for the configuration bank crossing.
package cfgx_pkg;

    // Receive-side settle controller state.
    typedef enum logic {
        SETTLE_IDLE = 1'b0,
        SETTLE_WAIT = 1'b1
    } settle_state_e;

endpackage

// File: rtl/cfgx_wr_bank.sv
// Write-domain register bank: NUM_REGS data words plus one qualifier bit.
// Assumes the writer loads every data word before it raises the qualifier.
module cfgx_wr_bank #(
    parameter int NUM_REGS = 4,
    parameter int REG_W    = 16,
    parameter int AW       = $clog2(NUM_REGS + 1)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic [AW-1:0]             wr_addr,
    input  logic [REG_W-1:0]          wr_data,
    output logic [NUM_REGS*REG_W-1:0] bank,
    output logic                      qual
);

    logic [REG_W-1:0] word_q [NUM_REGS];

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_word
        // Load one data word when its address is written.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                word_q[g] <= '0;
            end else if (wr_en && wr_addr == AW'(g)) begin
                word_q[g] <= wr_data;
            end
        end
        assign bank[g*REG_W +: REG_W] = word_q[g];
    end

    // Qualifier bit, written through the address just above the data words.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            qual <= 1'b0;
        end else if (wr_en && wr_addr == AW'(NUM_REGS)) begin
            qual <= wr_data[0];
        end
    end

    // R1: writes to unused addresses leave the bank and the qualifier untouched.
    a_r1_unused_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr > AW'(NUM_REGS)) |=> ($stable(bank) && $stable(qual)));

endmodule

// File: rtl/cfgx_sync2.sv
// Two-flop synchronizer for a single level signal entering the receive domain.
// Assumes the input holds each level for several receive clocks.
module cfgx_sync2 (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);

    logic meta_q;

    // Shift the asynchronous level through two flops.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= 1'b0;
            q      <= 1'b0;
        end else begin
            meta_q <= d;
            q      <= meta_q;
        end
    end

    // R3: the output only rises after the first stage has seen the level.
    a_r3_two_stage: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q) |-> $past(meta_q));

endmodule

// File: rtl/cfgx_settle_ctrl.sv
// Receive-domain controller: detects the rising edge of the synchronized
// qualifier, waits SETTLE_CYCLES clocks, then raises a one-cycle capture strobe.
// A rising edge seen while already waiting is ignored.
module cfgx_settle_ctrl
    import cfgx_pkg::*;
#(
    parameter int SETTLE_CYCLES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic qual_sync,
    output logic capture
);

    localparam int CW = $clog2(SETTLE_CYCLES + 1);

    settle_state_e     state_q;
    logic [CW-1:0]     cnt_q;
    logic              qual_d;
    logic              rise;

    initial begin
        assert (SETTLE_CYCLES >= 1) else $error("SETTLE_CYCLES must be at least 1");
    end

    // Remember the previous synchronized level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) qual_d <= 1'b0;
        else        qual_d <= qual_sync;
    end

    assign rise = qual_sync && !qual_d;

    // Count down the settle interval after an accepted rising edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SETTLE_IDLE;
            cnt_q   <= '0;
        end else if (state_q == SETTLE_WAIT) begin
            if (cnt_q == '0) state_q <= SETTLE_IDLE;
            else             cnt_q   <= cnt_q - 1'b1;
        end else if (rise) begin
            state_q <= SETTLE_WAIT;
            cnt_q   <= CW'(SETTLE_CYCLES - 1);
        end
    end

    assign capture = (state_q == SETTLE_WAIT) && (cnt_q == '0);

    // Checker support: cycles elapsed since the last accepted edge (saturating).
    logic [CW+1:0] age_q;
    always_ff @(posedge clk) begin
        if (!rst_n)                            age_q <= '1;
        else if (rise && state_q == SETTLE_IDLE) age_q <= (CW+2)'(1);
        else if (age_q != '1)                  age_q <= age_q + 1'b1;
    end

    // R4: capture lands exactly SETTLE_CYCLES clocks after the accepted edge.
    a_r4_settle_age: assert property (@(posedge clk) disable iff (!rst_n)
        capture |-> (age_q == (CW+2)'(SETTLE_CYCLES)));

    // R7: the capture strobe lasts one cycle.
    a_r7_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        capture |=> !capture);

endmodule

// File: rtl/cfgx_shadow.sv
// Receive-domain shadow bank: copies the raw bank on the capture strobe and
// flags completion one cycle later, together with the new values.
module cfgx_shadow #(
    parameter int BW = 64
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          capture,
    input  logic [BW-1:0] bank_in,
    output logic [BW-1:0] cfg_out,
    output logic          done
);

    // Copy the whole bank in the capture cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)       cfg_out <= '0;
        else if (capture) cfg_out <= bank_in;
    end

    // Completion pulse follows the capture strobe by one clock.
    always_ff @(posedge clk) begin
        if (!rst_n) done <= 1'b0;
        else        done <= capture;
    end

    // R7: outputs hold between captures.
    a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !capture |=> $stable(cfg_out));

    // R7: done only right after a capture.
    a_r7_done_after: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(capture));

endmodule

// File: rtl/cfgx_bank_xfer.sv
// Top: configuration bank crossing from a slow write clock to a fast receive
// clock. Only the qualifier is synchronized; data words are sampled after a
// settle interval. Assumes the write clock is much slower than the receive
// clock and that the writer clears the qualifier before each new update.
module cfgx_bank_xfer #(
    parameter  int NUM_REGS      = 4,
    parameter  int REG_W         = 16,
    parameter  int SETTLE_CYCLES = 2,
    localparam int AW            = $clog2(NUM_REGS + 1),
    localparam int BW            = NUM_REGS * REG_W
) (
    input  logic             wr_clk,
    input  logic             wr_rst_n,
    input  logic             wr_en,
    input  logic [AW-1:0]    wr_addr,
    input  logic [REG_W-1:0] wr_data,
    input  logic             rx_clk,
    input  logic             rx_rst_n,
    output logic [BW-1:0]    cfg_out,
    output logic             done
);

    logic [BW-1:0] bank_raw;
    logic          qual_wr;
    logic          qual_rx;
    logic          capture;

    cfgx_wr_bank #(.NUM_REGS(NUM_REGS), .REG_W(REG_W), .AW(AW)) u_bank (
        .clk     (wr_clk),
        .rst_n   (wr_rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .bank    (bank_raw),
        .qual    (qual_wr)
    );

    cfgx_sync2 u_sync (
        .clk   (rx_clk),
        .rst_n (rx_rst_n),
        .d     (qual_wr),
        .q     (qual_rx)
    );

    cfgx_settle_ctrl #(.SETTLE_CYCLES(SETTLE_CYCLES)) u_settle (
        .clk       (rx_clk),
        .rst_n     (rx_rst_n),
        .qual_sync (qual_rx),
        .capture   (capture)
    );

    cfgx_shadow #(.BW(BW)) u_shadow (
        .clk     (rx_clk),
        .rst_n   (rx_rst_n),
        .capture (capture),
        .bank_in (bank_raw),
        .cfg_out (cfg_out),
        .done    (done)
    );

endmodule

// File: tb/cfgx_bank_xfer_test.sv
`timescale 1ns/100ps
module cfgx_bank_xfer_test;

    localparam int  NR = 5;
    localparam int  RW = 8;
    localparam int  SC = 3;
    localparam int  AW = $clog2(NR + 1);
    localparam int  BW = NR * RW;
    localparam real WR_PERIOD = 41.6;
    localparam real RX_PERIOD = 10.6;

    logic          wr_clk = 1'b0, rx_clk = 1'b0;
    logic          wr_rst_n = 1'b0, rx_rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [RW-1:0] wr_data = '0;
    logic [BW-1:0] cfg_out;
    logic          done;

    int errors = 0, checks = 0;
    int rx_edges = 0, mark = 0, done_cnt = 0, hold_viol = 0;
    bit finished = 1'b0;
    logic [BW-1:0] exp_bank = '0;
    logic [BW-1:0] sb_q[$];
    logic [BW-1:0] last_out = '0;
    logic          last_done = 1'b0;

    cfgx_bank_xfer #(.NUM_REGS(NR), .REG_W(RW), .SETTLE_CYCLES(SC)) uut (
        .wr_clk, .wr_rst_n, .wr_en, .wr_addr, .wr_data,
        .rx_clk, .rx_rst_n, .cfg_out, .done
    );

    always #(WR_PERIOD / 2.0) wr_clk = ~wr_clk;
    initial begin
        #1.7;
        forever #(RX_PERIOD / 2.0) rx_clk = ~rx_clk;
    end

    always @(posedge rx_clk) rx_edges++;
    always @(posedge wr_clk)
        if (wr_rst_n && wr_en && wr_addr == AW'(NR) && wr_data[0]) mark = rx_edges;

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Monitor: pops the scoreboard on each completion pulse.
    always @(negedge rx_clk) begin
        if (rx_rst_n) begin
            if (done) begin
                done_cnt++;
                if (sb_q.size() == 0) begin
                    chk(1'b0, "R6 capture without qualifier edge", 64'(cfg_out), 64'(last_out));
                end else begin
                    logic [BW-1:0] e;
                    e = sb_q.pop_front();
                    chk(cfg_out === e, "R2 captured bank", 64'(cfg_out), 64'(e));
                end
                chk((rx_edges - mark) >= 2 + SC && (rx_edges - mark) <= 4 + SC,
                    "R3,R4 latency in receive edges", 64'(rx_edges - mark), 64'(3 + SC));
                chk(!last_done, "R7 done one cycle wide", 64'(last_done), 64'(0));
            end else if (cfg_out !== last_out) begin
                hold_viol++;
            end
            last_out  = cfg_out;
            last_done = done;
        end
    end

    task automatic wr_reg(input int a, input logic [RW-1:0] d);
        @(negedge wr_clk);
        wr_en = 1'b1; wr_addr = AW'(a); wr_data = d;
        @(negedge wr_clk);
        wr_en = 1'b0;
    endtask

    task automatic set_word(input int i, input logic [RW-1:0] d);
        wr_reg(i, d);
        exp_bank[i*RW +: RW] = d;
    endtask

    task automatic wait_done(input int start);
        for (int n = 0; n < 60 && done_cnt == start; n++) @(negedge rx_clk);
        chk(done_cnt > start, "R4 capture reached", 64'(done_cnt), 64'(start + 1));
    endtask

    // Driver: pushes the expected snapshot, raises the qualifier, waits, clears it.
    task automatic fire();
        int start;
        start = done_cnt;
        sb_q.push_back(exp_bank);
        wr_reg(NR, 8'h01);
        wait_done(start);
        wr_reg(NR, 8'h00);
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        #(WR_PERIOD * 20000.0);
        errors++; checks++;
        $display("FAIL watchdog actual=expired expected=completion");
        summary();
    end

    initial begin
        int start;
        repeat (4) @(negedge wr_clk);
        // R8: reset state
        chk(cfg_out === '0, "R8 cfg_out in reset", 64'(cfg_out), 64'(0));
        chk(done === 1'b0, "R8 done in reset", 64'(done), 64'(0));
        @(negedge rx_clk); rx_rst_n = 1'b1;
        @(negedge wr_clk); wr_rst_n = 1'b1;
        repeat (3) @(negedge rx_clk);
        chk(cfg_out === '0 && done === 1'b0, "R8 after reset release", 64'(cfg_out), 64'(0));

        // R2: full random updates
        for (int t = 0; t < 20; t++) begin
            for (int i = 0; i < NR; i++) set_word(i, RW'($urandom));
            fire();
        end

        // R1: partial update keeps untouched words
        set_word(1, 8'h3C);
        set_word(4, 8'hC3);
        fire();

        // R1: unused addresses 6 and 7 change nothing
        wr_reg(NR + 1, 8'hA5);
        wr_reg(NR + 2, 8'h5A);
        fire();

        // R6: writing 0 to a low qualifier starts nothing
        start = done_cnt;
        wr_reg(NR, 8'h00);
        repeat (30) @(negedge rx_clk);
        chk(done_cnt == start, "R6 zero write no capture", 64'(done_cnt), 64'(start));

        // R5: qualifier held high; data changes and rewrites ignored
        for (int i = 0; i < NR; i++) set_word(i, RW'($urandom));
        start = done_cnt;
        sb_q.push_back(exp_bank);
        wr_reg(NR, 8'h01);
        wait_done(start);
        begin
            logic [BW-1:0] snap;
            snap = exp_bank;
            set_word(0, ~exp_bank[RW-1:0]);
            set_word(2, 8'h77);
            wr_reg(NR, 8'h01);
            repeat (40) @(negedge rx_clk);
            chk(done_cnt == start + 1, "R5 no recapture while high", 64'(done_cnt), 64'(start + 1));
            chk(cfg_out === snap, "R5 outputs unchanged while high", 64'(cfg_out), 64'(snap));
        end
        wr_reg(NR, 8'h00);
        fire();   // R5: new edge picks up words written while high

        repeat (30) @(negedge rx_clk);
        chk(hold_viol == 0, "R7 outputs change only at capture", 64'(hold_viol), 64'(0));
        chk(sb_q.size() == 0, "R6 every edge captured once", 64'(sb_q.size()), 64'(0));
        summary();
    end

endmodule